// File: doc/BRIEF.md
# Hit Pipeline with Trigger Capture

This block is the digital heart of a 64-channel front-end readout. On every timing tick, nominally one every 100 ns, it stamps the 64 discriminator hit bits with a 24-bit time counter. The stamped sample goes into a fixed-length delay line. A capture stage then chooses which samples become records in a small output queue. In external mode, a trigger selects the sample that entered the delay line a fixed number of ticks earlier. In self mode, every tick that carries at least one hit is kept. A record whose hit pattern is all zero is never stored.

A prompt trigger output shows at once whether any channel is firing. A synchronisation input lets many front ends restart their time counters together. The downstream reader drains records through a show-ahead read port. If a record arrives while the queue is full, it is lost, and a sticky flag reports the loss.

Top module: `hit_capture_core`

## Requirements
- R1: `prompt_trig` is high in exactly those cycles in which at least one bit of `hits` is high.
- R2: Each tick stamps its sample with the previous tick's stamp plus one, modulo 2^24. The first tick after reset carries stamp 0.
- R3: A pulse on `ts_sync` makes the next tick stamp its sample 0. This holds whether the pulse comes on that tick or in an earlier cycle. The ticks after it count up from 0.
- R4: In external mode (`self_mode` = 0), a trigger raised on a tick or in any cycle since the previous tick is acted on at that tick. The captured record is the sample stamped LAT ticks earlier (default 20), with its own stamp and not the current one. Several triggers between two ticks give one capture.
- R5: In self mode (`self_mode` = 1), every tick whose `hits` is non-zero stores `{hits, stamp}` of that tick, and `ext_trig` has no effect.
- R6: A captured record whose 64 hit bits are all zero is not stored. Ticks seen before LAT samples exist count as empty.
- R7: The queue holds up to 7 records and returns them oldest first. `rd_valid` is high while it holds a record, `rd_hits`/`rd_ts` show the oldest one, and `rd_en` with `rd_valid` removes it at the clock edge.
- R8: A record that arrives while 7 are held is dropped, even if a read happens in the same cycle. `overflow` then rises and stays high until reset.
- R9: After reset the queue is empty, `overflow` is low and no trigger is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe marking a sampling instant |
| hits | input | 64 | Discriminator hit bits, one per channel |
| ts_sync | input | 1 | Time counter synchronisation pulse |
| ext_trig | input | 1 | External trigger pulse |
| self_mode | input | 1 | 1 = self trigger, 0 = external trigger |
| prompt_trig | output | 1 | OR of all current hit bits |
| rd_en | input | 1 | Remove the oldest record |
| rd_valid | output | 1 | A record is available |
| rd_hits | output | 64 | Hit pattern of the oldest record |
| rd_ts | output | 24 | Stamp of the oldest record |
| overflow | output | 1 | Sticky record-loss flag |

## Verification
Several properties are checked on every cycle:
- the stamp steps by one on each tick, and is cleared by a tick that has a sync pending;
- an all-zero pattern is never written;
- a write never happens at full occupancy;
- the loss flag stays set once set;
- self mode never takes an external capture, and a self capture always shows the prompt bit.

Other behaviour only the bench scenarios can show: that an external capture returns the sample from exactly LAT ticks back together with that sample's stamp, that triggers merge between ticks, and that records leave in order. The bench shows these by following a queue-based model through each mode, through a sync in mid-run, and through a fill past capacity followed by a drain.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  localparam int unsigned HCC_NCH    = 64;
  localparam int unsigned HCC_TSW    = 24;
  localparam int unsigned HCC_LAT    = 20;
  localparam int unsigned HCC_FDEPTH = 7;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_EXT  = 2'd1,
    CAP_SELF = 2'd2
  } cap_src_e;
endpackage

// File: rtl/hcc_timebase.sv
module hcc_timebase #(
  parameter int unsigned TSW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           sync_in,
  output logic [TSW-1:0] stamp_q,
  output logic [TSW-1:0] stamp_now,
  output logic           sync_req
);
  logic sync_pend;

  function automatic logic [TSW-1:0] next_stamp(input logic [TSW-1:0] cur, input logic clr);
    return clr ? '0 : cur + 1'b1;
  endfunction

  assign sync_req  = sync_in | sync_pend;
  assign stamp_now = next_stamp(stamp_q, sync_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q   <= '1;
      sync_pend <= 1'b0;
    end else if (tick) begin
      stamp_q   <= stamp_now;
      sync_pend <= 1'b0;
    end else if (sync_in) begin
      sync_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/hcc_delay_line.sv
module hcc_delay_line #(
  parameter int unsigned W     = 88,
  parameter int unsigned DEPTH = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     stage[0] <= '0;
        else if (shift) stage[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)     stage[g] <= '0;
        else if (shift) stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/hcc_record_fifo.sv
module hcc_record_fifo #(
  parameter int unsigned W     = 88,
  parameter int unsigned DEPTH = 7,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign push     = wr_en & ~full;
  assign pop      = rd_en & rd_valid;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hit_capture_core.sv
module hit_capture_core
  import hcc_pkg::*;
#(
  parameter int unsigned NCH    = HCC_NCH,
  parameter int unsigned TSW    = HCC_TSW,
  parameter int unsigned LAT    = HCC_LAT,
  parameter int unsigned FDEPTH = HCC_FDEPTH,
  localparam int unsigned RW    = NCH + TSW,
  localparam int unsigned CW    = $clog2(FDEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] hits,
  input  logic           ts_sync,
  input  logic           ext_trig,
  input  logic           self_mode,
  output logic           prompt_trig,
  input  logic           rd_en,
  output logic           rd_valid,
  output logic [NCH-1:0] rd_hits,
  output logic [TSW-1:0] rd_ts,
  output logic           overflow
);
  // named internal events, observed by the bound checker
  logic [TSW-1:0] stamp_q, stamp_now;
  logic           sync_req;
  logic           trig_pend;
  logic           cap_ext, cap_self, cap_any, cap_hit;
  logic           fifo_wr, fifo_full, drop;
  logic [CW-1:0]  fifo_cnt;
  logic [RW-1:0]  sample_now, sample_old, cap_rec, head_rec;
  logic [NCH-1:0] wr_hits;
  cap_src_e       cap_src;

  hcc_timebase #(.TSW(TSW)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_in(ts_sync),
    .stamp_q(stamp_q), .stamp_now(stamp_now), .sync_req(sync_req)
  );

  assign sample_now  = {hits, stamp_now};
  assign prompt_trig = |hits;

  hcc_delay_line #(.W(RW), .DEPTH(LAT)) u_delay (
    .clk(clk), .rst_n(rst_n), .shift(tick), .din(sample_now), .dout(sample_old)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     trig_pend <= 1'b0;
    else if (tick)                  trig_pend <= 1'b0;
    else if (ext_trig && !self_mode) trig_pend <= 1'b1;
  end

  assign cap_ext  = tick & ~self_mode & (ext_trig | trig_pend);
  assign cap_self = tick & self_mode & prompt_trig;

  always_comb begin
    if (cap_self)     cap_src = CAP_SELF;
    else if (cap_ext) cap_src = CAP_EXT;
    else              cap_src = CAP_NONE;
    unique case (cap_src)
      CAP_SELF: cap_rec = sample_now;
      CAP_EXT:  cap_rec = sample_old;
      default:  cap_rec = '0;
    endcase
  end

  assign wr_hits = cap_rec[RW-1:TSW];
  assign cap_any = (cap_src != CAP_NONE);
  assign cap_hit = cap_any & (|wr_hits);
  assign fifo_wr = cap_hit & ~fifo_full;
  assign drop    = cap_hit & fifo_full;

  hcc_record_fifo #(.W(RW), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(cap_rec),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(head_rec),
    .full(fifo_full), .count(fifo_cnt)
  );

  assign rd_hits = head_rec[RW-1:TSW];
  assign rd_ts   = head_rec[TSW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end
endmodule

// File: rtl/hcc_checker.sv
module hcc_checker #(
  parameter int unsigned NCH    = 64,
  parameter int unsigned TSW    = 24,
  parameter int unsigned FDEPTH = 7,
  localparam int unsigned CW    = $clog2(FDEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           self_mode,
  input logic           sync_req,
  input logic [TSW-1:0] stamp_q,
  input logic           cap_ext,
  input logic           cap_self,
  input logic           prompt_trig,
  input logic           fifo_wr,
  input logic [NCH-1:0] wr_hits,
  input logic [CW-1:0]  fifo_cnt,
  input logic           rd_valid,
  input logic           overflow
);
  // R2
  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_req) |=> (stamp_q == $past(stamp_q) + 1'b1));
  // R3
  p_ts_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sync_req) |=> (stamp_q == '0));
  // R5
  p_self_no_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    self_mode |-> !cap_ext);
  // R5 with R1
  p_self_prompt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_self |-> prompt_trig);
  // R6
  p_zero_sup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (wr_hits != '0));
  // R7
  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt != '0) |-> rd_valid);
  // R8
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(FDEPTH)) |-> !fifo_wr);
  // R8
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind hit_capture_core hcc_checker #(.NCH(NCH), .TSW(TSW), .FDEPTH(FDEPTH)) u_hcc_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .self_mode(self_mode),
  .sync_req(sync_req), .stamp_q(stamp_q), .cap_ext(cap_ext), .cap_self(cap_self),
  .prompt_trig(prompt_trig), .fifo_wr(fifo_wr), .wr_hits(wr_hits),
  .fifo_cnt(fifo_cnt), .rd_valid(rd_valid), .overflow(overflow)
);

// File: tb/test_hit_capture_core.sv
module test_hit_capture_core;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 20;
  localparam int QCAP = 7;

  typedef struct { logic [63:0] h; logic [23:0] t; } rec_t;

  logic        clk = 0, rst_n = 0;
  logic        tick = 0, ts_sync = 0, ext_trig = 0, self_mode = 0, rd_en = 0;
  logic [63:0] hits = '0;
  logic        prompt_trig, rd_valid, overflow;
  logic [63:0] rd_hits;
  logic [23:0] rd_ts;

  int checks = 0, failures = 0;
  string tag = "R9";
  bit done = 0;

  // behavioural reference state
  rec_t q[$];
  rec_t hist[$];
  int   next_ts = 0;
  bit   spend = 0, tpend = 0, m_ovf = 0;

  hit_capture_core i_hit_capture_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hits(hits), .ts_sync(ts_sync),
    .ext_trig(ext_trig), .self_mode(self_mode), .prompt_trig(prompt_trig),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_hits(rd_hits), .rd_ts(rd_ts),
    .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); hist.delete();
      next_ts = 0; spend = 0; tpend = 0; m_ovf = 0;
    end else begin
      rec_t r, s;
      bit take, was_full;
      int st;
      take = 0; st = 0;
      r.h = '0; r.t = '0;
      if (tick) begin
        st = (spend || ts_sync) ? 0 : next_ts;
        next_ts = (st + 1) % (1 << 24);
        spend = 0;
        s.h = hits; s.t = st[23:0];
        if (!self_mode && (ext_trig || tpend)) begin
          take = 1;
          if (hist.size() >= LAT) r = hist[LAT-1];
        end
        if (self_mode && hits != 0) begin
          take = 1; r = s;
        end
        hist.push_front(s);
        if (hist.size() > LAT) void'(hist.pop_back());
        tpend = 0;
      end else begin
        if (ts_sync) spend = 1;
        if (ext_trig && !self_mode) tpend = 1;
      end
      was_full = (q.size() == QCAP);
      if (rd_en && q.size() > 0) void'(q.pop_front());
      if (take && r.h != 0) begin
        if (was_full) m_ovf = 1;
        else q.push_back(r);
      end
    end
  end

  // output comparison away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        // no comparison during reset
      end else begin
        chk({"R1 ", tag}, 64'(prompt_trig), 64'(hits != 0));
        chk({"R7 ", tag}, 64'(rd_valid), 64'(q.size() > 0));
        if (q.size() > 0) begin
          chk({"R2 R3 R7 ", tag}, 64'(rd_ts), 64'(q[0].t));
          chk({"R4 R5 R7 ", tag}, rd_hits, q[0].h);
        end
        chk({"R8 ", tag}, 64'(overflow), 64'(m_ovf));
      end
    end
  end

  task automatic run(input int ncyc, input bit smode, input int hit_pct,
                     input int trig_pct, input bit rd);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      self_mode = smode;
      tick      = (i % 3 == 0);
      rd_en     = rd;
      ext_trig  = ($urandom % 100) < trig_pct;
      ts_sync   = 0;
      if (($urandom % 100) < hit_pct) begin
        hits = {$urandom, $urandom} & {$urandom, $urandom};
        hits[$urandom % 64] = 1'b1;
      end else hits = '0;
    end
  endtask

  task automatic sync_pulse(input bit on_tick);
    @(posedge clk); #(CLK_PERIOD/4);
    tick = on_tick; ts_sync = 1; ext_trig = 0; hits = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    chk("R9 empty", 64'(rd_valid), 64'd0);
    chk("R9 overflow", 64'(overflow), 64'd0);

    tag = "R1 R4 R6";                 // external mode, delayed capture
    run(240, 1'b0, 40, 15, 1'b1);
    tag = "R4 merge";                 // dense triggers merge per tick
    run(120, 1'b0, 60, 70, 1'b1);
    tag = "R3";                       // sync away from tick, then on tick
    sync_pulse(1'b0);
    run(30, 1'b0, 50, 20, 1'b1);
    sync_pulse(1'b1);
    run(90, 1'b0, 50, 20, 1'b1);
    tag = "R5 R6";                    // self mode, trigger ignored, sparse hits
    run(240, 1'b1, 25, 50, 1'b1);
    tag = "R2";
    run(60, 1'b1, 100, 0, 1'b1);
    tag = "R8 fill";                  // fill past capacity without reading
    run(60, 1'b1, 100, 0, 1'b0);
    tag = "R8 R7 drain";
    run(40, 1'b1, 0, 0, 1'b1);
    tag = "R4 after overflow";
    run(150, 1'b0, 40, 15, 1'b1);

    @(negedge clk);
    chk("R8 sticky", 64'(overflow), 64'd1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule